// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block watches for a stalled system. A 10-bit counter is loaded from a programmable reload value and counts down by one on each pulse of a slow tick-enable input. The tick-enable input takes the place of a prescaler, and one tick nominally stands for about 21.5 ms. Firmware keeps the system alive by writing a one to a kick bit, which loads the counter again from the reload value. When the counter reaches zero, the block pulses a reset request for one clock.

Before expiry, a second programmable value, the warning threshold, raises a sticky interrupt when the running count matches it. This gives software a chance to kick late rather than never. A reload value of zero turns the whole function off.

Software reaches the block through four word-addressed registers:

| Index | Register | Access |
|-------|----------|--------|
| 0 | Control | Write-one kick, reads as zero |
| 1 | Reload value | Read/write |
| 2 | Warning threshold | Read/write |
| 3 | Running count | Read-only |

A write strobe and a read strobe share the index. Read data comes back one cycle after the read strobe.

Top module: `wdog_guard`

## Requirements
- R1: After reset, all four registers read 0, and `irq` and `rst_req` are low.
- R2: The reload value and the threshold keep only bits 9:0 of a write. Bits 31:10 of every register read as 0. Writes to index 3 (count) are ignored.
- R3: Asserting `rd_en` with `addr` places that register on `rdata` in the following cycle. The indices are 0 control, 1 reload, 2 threshold and 3 count.
- R4: Index 0 always reads 0. Writing it with bit 0 clear leaves the count and `irq` unchanged.
- R5: Writing a nonzero reload value while the reload register holds 0 loads the counter with that value at once.
- R6: While the reload value is nonzero, each cycle with `tick_en` high lowers a nonzero count by exactly one. The count holds in cycles without `tick_en`.
- R7: When a tick takes the count from 1 to 0, `rst_req` is high for exactly one cycle, the cycle in which the count first reads 0. The count then stays at 0 under further ticks, and no further pulse follows.
- R8: Writing index 0 with bit 0 set, while enabled, loads the counter from the reload register. This load wins over a tick in the same cycle.
- R9: `irq` rises one cycle after the count equals the threshold. It stays high until a kick or a disable clears it.
- R10: Writing 0 to the reload register clears the count and `irq`. While the reload value is 0, ticks and kicks leave the count at 0, and neither `irq` nor `rst_req` is raised.
- R11: Writing a new nonzero reload value while enabled does not change the running count. The new value is used from the next kick on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle prescaled tick pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Sticky early-warning interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest case to reach is a kick and a tick landing in the very same clock. The bench drives both strobes in one cycle and reads the count back. A second hard case is the held-at-zero state after expiry, where further ticks must produce no second pulse. The bench counts every `rst_req` cycle in a monitor and compares the running total before and after extra ticks. The scoreboard queues each expected read value as the driver issues the strobe, and pops it in the cycle the data returns.

// File: rtl/wdog_guard_pkg.sv
package wdog_guard_pkg;

  // Word index of each register; the bench and software rely on these.
  typedef enum logic [1:0] {
    IDX_CTRL   = 2'd0,
    IDX_RELOAD = 2'd1,
    IDX_THRESH = 2'd2,
    IDX_COUNT  = 2'd3
  } reg_idx_e;

  // Bit position of the kick inside the control word.
  localparam int unsigned KICK_BIT = 0;

endpackage

// File: rtl/wdog_guard_regs.sv
module wdog_guard_regs
  import wdog_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  thresh_q,
  output logic              kick,
  output logic              disarm,
  output logic              start,
  output logic [CNT_W-1:0]  wval,
  output logic [DATA_W-1:0] rdata
);

  logic [CNT_W-1:0]  reload_d;
  logic [CNT_W-1:0]  thresh_d;
  logic [DATA_W-1:0] rdata_d;
  logic              reload_wr;
  logic              thresh_wr;

  // Decode of the write strobe.
  always_comb begin
    wval      = wdata[CNT_W-1:0];
    reload_wr = wr_en && (reg_idx_e'(addr) == IDX_RELOAD);
    thresh_wr = wr_en && (reg_idx_e'(addr) == IDX_THRESH);
    kick      = wr_en && (reg_idx_e'(addr) == IDX_CTRL) && wdata[KICK_BIT];
    disarm    = reload_wr && (wval == '0);
    start     = reload_wr && (wval != '0) && (reload_q == '0);
  end

  // Next-state logic of the stored registers.
  always_comb begin
    reload_d = reload_q;
    thresh_d = thresh_q;
    if (reload_wr) reload_d = wval;
    if (thresh_wr) thresh_d = wval;
  end

  // Read multiplexer; reserved bits and the control word read as zero.
  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      rdata_d = '0;
      unique case (reg_idx_e'(addr))
        IDX_CTRL:   rdata_d = '0;
        IDX_RELOAD: rdata_d[CNT_W-1:0] = reload_q;
        IDX_THRESH: rdata_d[CNT_W-1:0] = thresh_q;
        IDX_COUNT:  rdata_d[CNT_W-1:0] = count_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      thresh_q <= '0;
      rdata    <= '0;
    end else begin
      reload_q <= reload_d;
      thresh_q <= thresh_d;
      rdata    <= rdata_d;
    end
  end

endmodule

// File: rtl/wdog_guard_counter.sv
module wdog_guard_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             kick,
  input  logic             disarm,
  input  logic             start,
  input  logic [CNT_W-1:0] wval,
  input  logic [CNT_W-1:0] reload_q,
  output logic             enabled,
  output logic [CNT_W-1:0] count_q,
  output logic             rst_req
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_d;
  logic             rst_req_d;
  logic             step;

  always_comb begin
    enabled = (reload_q != '0);
    step    = enabled && tick_en && (count_q != '0);
  end

  // Priority: disable, then kick, then first load, then tick.
  always_comb begin
    count_d = count_q;
    if (disarm) begin
      count_d = '0;
    end else if (kick && enabled) begin
      count_d = reload_q;
    end else if (start) begin
      count_d = wval;
    end else if (step) begin
      count_d = count_q - ONE;
    end
  end

  always_comb begin
    rst_req_d = step && !disarm && !kick && (count_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rst_req <= 1'b0;
    end else begin
      count_q <= count_d;
      rst_req <= rst_req_d;
    end
  end

endmodule

// File: rtl/wdog_guard_irq.sv
module wdog_guard_irq #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             kick,
  input  logic             disarm,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] thresh_q,
  output logic             irq
);

  logic irq_d;
  logic hit;

  always_comb begin
    hit   = enabled && (count_q == thresh_q);
    irq_d = irq;
    if (kick || disarm || !enabled) begin
      irq_d = 1'b0;
    end else if (hit) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] thresh_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] wval;
  logic             kick;
  logic             disarm;
  logic             start;
  logic             enabled;

  wdog_guard_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .count_q  (count_q),
    .reload_q (reload_q),
    .thresh_q (thresh_q),
    .kick     (kick),
    .disarm   (disarm),
    .start    (start),
    .wval     (wval),
    .rdata    (rdata)
  );

  wdog_guard_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .kick     (kick),
    .disarm   (disarm),
    .start    (start),
    .wval     (wval),
    .reload_q (reload_q),
    .enabled  (enabled),
    .count_q  (count_q),
    .rst_req  (rst_req)
  );

  wdog_guard_irq #(.CNT_W(CNT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enabled  (enabled),
    .kick     (kick),
    .disarm   (disarm),
    .count_q  (count_q),
    .thresh_q (thresh_q),
    .irq      (irq)
  );

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wlo,
  input logic             irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_q
);

  logic kick_c;
  logic off_wr_c;

  always_comb begin
    kick_c   = wr_en && (addr == 2'd0) && wlo[0];
    off_wr_c = wr_en && (addr == 2'd1) && (wlo == '0);
  end

  // R7: the expiry request never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7: the request coincides with a zero count
  a_r7_req_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count_q == '0));

  // R6: one tick lowers a running count by one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q != '0 && tick_en && count_q != '0 && !wr_en)
      |=> ((count_q + CNT_W'(1)) == $past(count_q)));

  // R8: a kick while enabled reloads the counter
  a_r8_kick_load: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_c && reload_q != '0) |=> (count_q == $past(reload_q)));

  // R9: the warning stays up until a kick or a disable
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick_c && !off_wr_c) |=> irq);

  // R9: a kick drops the warning
  a_r9_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick_c |=> !irq);

  // R10: a disabled watchdog stays silent with a zero count
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0) |-> (!irq && !rst_req && count_q == '0));

endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wlo      (wdata[CNT_W-1:0]),
  .irq      (irq),
  .rst_req  (rst_req),
  .reload_q (reload_q),
  .count_q  (count_q)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic        rst_req;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  int   pulses = 0;
  logic rd_seen;
  bit   finished = 0;

  wdog_guard u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .rst_req (rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: pops the expected read value when the data returns.
  always @(negedge clk) begin
    if (rst_req) pulses = pulses + 1;
    if (rd_seen === 1'b1 && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp = n_cmp + 1;
      if (rdata !== e.val) begin
        n_bad = n_bad + 1;
        $display("FAIL %s: rdata=%h expected=%h", e.tag, rdata, e.val);
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    n_cmp = n_cmp + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_t item;
    @(negedge clk);
    item.val = e; item.tag = tag;
    exp_q.push_back(item);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int p0;
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = 2'd0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check_bit(irq, 1'b0, "R1 irq");
    check_bit(rst_req, 1'b0, "R1 rst_req");
    rd(2'd0, 32'h0, "R1 ctrl");
    rd(2'd1, 32'h0, "R1 reload");
    rd(2'd2, 32'h0, "R1 thresh");
    rd(2'd3, 32'h0, "R1 count");

    // R2 width masking, R3 read path
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0000_03FF, "R2 thresh masked");
    wr(2'd2, 32'd3);
    rd(2'd2, 32'd3, "R3 thresh readback");
    wr(2'd3, 32'h55);
    rd(2'd3, 32'h0, "R2 count write ignored");

    // R5 first load starts the counter
    wr(2'd1, 32'hFFFF_FC08);
    rd(2'd1, 32'd8, "R2 reload masked");
    rd(2'd3, 32'd8, "R5 immediate load");

    // R6 tick stepping and hold
    tick(1);
    idle(3);
    rd(2'd3, 32'd7, "R6 one tick");
    rd(2'd3, 32'd7, "R6 hold without tick");

    // R4 kick bit clear has no effect
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd3, 32'd7, "R4 zero kick");
    rd(2'd0, 32'h0, "R4 ctrl reads zero");

    // R9 warning at threshold, sticky
    tick(4);
    idle(1);
    check_bit(irq, 1'b1, "R9 irq at threshold");
    tick(1);
    idle(1);
    check_bit(irq, 1'b1, "R9 irq sticky");
    rd(2'd3, 32'd2, "R6 count after five ticks");

    // R8 kick reloads and clears warning
    wr(2'd0, 32'd1);
    check_bit(irq, 1'b0, "R9 kick clears irq");
    rd(2'd3, 32'd8, "R8 kick reload");

    // R8 kick wins over a tick in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 32'd1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd(2'd3, 32'd8, "R8 kick over tick");

    // R11 reload change while running waits for a kick
    wr(2'd1, 32'd5);
    rd(2'd3, 32'd8, "R11 count untouched");
    wr(2'd0, 32'd1);
    rd(2'd3, 32'd5, "R11 new reload on kick");

    // R7 expiry pulse and hold at zero
    p0 = pulses;
    tick(5);
    idle(2);
    check_int(pulses - p0, 1, "R7 one pulse");
    rd(2'd3, 32'd0, "R7 count at zero");
    tick(3);
    idle(2);
    check_int(pulses - p0, 1, "R7 no second pulse");
    rd(2'd3, 32'd0, "R7 count held");
    check_bit(irq, 1'b1, "R9 irq still high after expiry");

    // R10 disable
    wr(2'd1, 32'd0);
    check_bit(irq, 1'b0, "R10 irq cleared");
    p0 = pulses;
    tick(4);
    wr(2'd0, 32'd1);
    idle(2);
    rd(2'd3, 32'd0, "R10 count stays zero");
    rd(2'd1, 32'd0, "R10 reload zero");
    check_int(pulses - p0, 0, "R10 no pulse");
    check_bit(irq, 1'b0, "R10 no irq");

    // R9 and R7 with threshold zero
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd2);
    rd(2'd3, 32'd2, "R5 reload two");
    p0 = pulses;
    tick(2);
    idle(2);
    check_int(pulses - p0, 1, "R7 short expiry");
    check_bit(irq, 1'b1, "R9 irq at zero threshold");

    idle(4);
    check_int(exp_q.size(), 0, "R3 all reads returned");
    finish_run();
  end

endmodule